// File: doc/BRIEF.md
# PCI INTx Status and Mask Control Register

This block is one 32-bit control word for a PCI host bridge. It latches four level-sensitive legacy interrupt lines (INTA to INTD) into sticky pending bits. Each line has its own enable. The block drives a single combined interrupt request toward the system interrupt controller. The same word also holds enables for eight bus error events, priority flags for seven bus request lines, and a target-ready wait count. The priority flags and the wait count are passed straight out to the arbiter and the target logic.

Software reads the whole word through a read port and writes it through a word, halfword or byte write port with byte enables. The pending bits are write-one-to-clear. Writing zero to them leaves them unchanged, so the enables can be rewritten without losing pending events. Error events arrive from outside as single-cycle pulses. When their enable bit is set, they reach the interrupt output in the same cycle.

Top module: `pci_intx_ctl_reg`

## Requirements
- R1: A high level on `intx_in[i]` at a rising clock edge sets pending bit 28+i (bit 28 is INTA, bit 31 is INTD), and the bit reads back from the next cycle on.
- R2: A pending bit stays set after its input falls, until software clears it.
- R3: A write with `wr_be[3]` high clears each pending bit whose `wr_data` bit is 1. A 0 leaves the bit unchanged, and no clear takes place when `wr_be[3]` is low. If the input line is high in the same cycle, the bit stays set.
- R4: Bits 25:22 enable INTD..INTA (bit 22 is INTA), where 1 lets the line interrupt. `irq_out` is high whenever any pending bit has its enable set.
- R5: Error enables sit at bit 16 (`err_in[0]`, received PERR), 17 (`err_in[1]`, received SERR), 18 (`err_in[2]`, retry limit), 19 (`err_in[3]`, target abort sent), 20 (`err_in[4]`, target abort received), 21 (`err_in[5]`, master abort received), 26 (`err_in[6]`, parity error) and 27 (`err_in[7]`, command error). An `err_in` pulse drives `irq_out` high in the same cycle exactly when its enable bit is set.
- R6: Bits 14:8 hold the priority flags for request lines 6..0 and bits 3:0 hold the wait count; both read back as written and appear on `req_prio` and `trdy_wait`. Bits 15 and 7:4 always read 0.
- R7: A write changes only the byte lanes whose `wr_be` bit is set (lane k covers bits 8k+7:8k).
- R8: A halfword write of 0xF000 to the upper lanes (`wr_be`=4'b1100, `wr_data`[31:16]=16'hF000) clears all pending bits and disables all four lines in one cycle.
- R9: After reset, the register reads 0 and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 4 | Byte lane enables |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| intx_in | input | 4 | INTD..INTA levels, active high |
| err_in | input | 8 | Bus error event pulses |
| irq_out | output | 1 | Combined interrupt request |
| req_prio | output | 7 | Request priority flags to the arbiter |
| trdy_wait | output | 4 | Target-ready wait count |

## Verification
The assertions take for granted that `intx_in` and `err_in` are already synchronous to `clk`. They also assume that `wr_be` and `wr_data` are only meaningful while `wr_en` is high. The bench changes every input at the falling edge, so each value is stable across the next rising edge. The bench raises an interrupt line together with a clearing write only in the one case that checks that the set wins.

// File: rtl/pci_intx_ctl_reg.sv
module pci_intx_ctl_reg #(
  parameter int LINES  = 4,
  parameter int ERRS   = 8,
  parameter int REQS   = 7,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [LINES-1:0]  intx_in,
  input  logic [ERRS-1:0]   err_in,
  output logic              irq_out,
  output logic [REQS-1:0]   req_prio,
  output logic [WAIT_W-1:0] trdy_wait
);

  localparam int ST_LO = 32 - LINES;
  localparam int EN_LO = 22;
  localparam int PR_LO = 8;

  logic [LINES-1:0]  pend, lnen;
  logic [ERRS-1:0]   emsk;
  logic [REQS-1:0]   prio;
  logic [WAIT_W-1:0] wcnt;

  wire [3:0] lane = {4{wr_en}} & wr_be;
  wire [LINES-1:0] w1c = {LINES{lane[3]}} & wr_data[31:ST_LO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      lnen <= '0;
      emsk <= '0;
      prio <= '0;
      wcnt <= '0;
    end else begin
      pend <= (pend & ~w1c) | intx_in;
      if (lane[3]) begin
        emsk[7:6] <= wr_data[27:26];
        lnen[3:2] <= wr_data[25:24];
      end
      if (lane[2]) begin
        lnen[1:0] <= wr_data[23:EN_LO];
        emsk[5:0] <= wr_data[21:16];
      end
      if (lane[1]) prio <= wr_data[PR_LO+REQS-1:PR_LO];
      if (lane[0]) wcnt <= wr_data[WAIT_W-1:0];
    end
  end

  assign rd_data   = {pend, emsk[7:6], lnen, emsk[5:0], 1'b0, prio, 4'b0000, wcnt};
  assign irq_out   = (|(pend & lnen)) | (|(err_in & emsk));
  assign req_prio  = prio;
  assign trdy_wait = wcnt;

  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (intx_in != '0) |=> ((rd_data[31:ST_LO] & $past(intx_in)) == $past(intx_in)));

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_be[3]) |=> ((rd_data[31:ST_LO] & $past(rd_data[31:ST_LO])) == $past(rd_data[31:ST_LO])));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[3] && intx_in == '0) |=> ((rd_data[31:ST_LO] & $past(wr_data[31:ST_LO])) == '0));

  p_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[1]) |=> (req_prio == $past(wr_data[PR_LO+REQS-1:PR_LO])));

  p_mass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be == 4'b1100 && wr_data[31:16] == 16'hF000 && intx_in == '0)
      |=> (rd_data[31:ST_LO] == '0 && rd_data[25:EN_LO] == '0));

endmodule

// File: tb/test_pci_intx_ctl_reg.sv
module test_pci_intx_ctl_reg;
  logic clk = 0, rst_n = 0, wr_en = 0, irq_out;
  logic [3:0] wr_be = 0, intx_in = 0, trdy_wait;
  logic [31:0] wr_data = 0, rd_data;
  logic [7:0] err_in = 0;
  logic [6:0] req_prio;
  int checks = 0, fails = 0;
  logic [3:0] m_sts = 0;
  logic [31:0] m_ctl = 0;
  localparam logic [31:0] WMASK = 32'h0FFF7F0F;

  always #5 clk = ~clk;

  pci_intx_ctl_reg i_pci_intx_ctl_reg (.clk, .rst_n, .wr_en, .wr_be, .wr_data, .rd_data,
    .intx_in, .err_in, .irq_out, .req_prio, .trdy_wait);

  function automatic logic [31:0] exp_rd();
    return {m_sts, 28'h0} | m_ctl;
  endfunction
  function automatic logic exp_irq();
    logic [7:0] em;
    em = {m_ctl[27:26], m_ctl[21:16]};
    return (|(m_sts & m_ctl[25:22])) | (|(err_in & em));
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] be, logic [31:0] d);
    logic [31:0] bm;
    @(negedge clk);
    wr_en = 1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_be = 0;
    bm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    m_ctl = (m_ctl & ~(bm & WMASK)) | (d & bm & WMASK);
    if (be[3]) m_sts = m_sts & ~d[31:28];
  endtask

  task automatic pulse(logic [3:0] s);
    @(negedge clk);
    intx_in = s;
    @(negedge clk);
    intx_in = 0;
    m_sts = m_sts | s;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1;
    chk("R9 reset rd", rd_data, 0);
    chk("R9 reset irq", irq_out, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 after release", rd_data, 0);

    wr(4'b0011, 32'hFFFFFFFF);
    chk("R6 reserved zero", rd_data, 32'h00007F0F);
    chk("R6 prio port", req_prio, 7'h7F);
    chk("R6 wait port", trdy_wait, 4'hF);

    for (int be = 0; be < 16; be++) begin
      wr(be[3:0], 32'h5A5A5A5A ^ (be * 32'h11111111));
      chk("R7 lane write", rd_data, exp_rd());
      chk("R7 irq quiet", irq_out, exp_irq());
    end

    for (int en = 0; en < 16; en++)
      for (int s = 0; s < 16; s++) begin
        wr(4'b1100, {4'hF, 2'b00, en[3:0], 22'h0});
        pulse(s[3:0]);
        chk("R1 R2 capture", rd_data[31:28], 32'(s));
        chk("R4 line irq", irq_out, 32'(|(s[3:0] & en[3:0])));
      end

    wr(4'b1100, 32'hF3C00000);
    pulse(4'hF);
    wr(4'b1000, 32'h50000000);
    chk("R3 partial clear", rd_data[31:28], 4'hA);
    wr(4'b0111, 32'hF0000000);
    chk("R3 no lane no clear", rd_data[31:28], 4'hA);
    @(negedge clk);
    wr_en = 1; wr_be = 4'b1000; wr_data = 32'h23C00000; intx_in = 4'h2;
    @(negedge clk);
    wr_en = 0; wr_be = 0; intx_in = 0;
    chk("R3 set wins", rd_data[31:28], 4'hA);
    m_sts = 4'hA;

    for (int k = 0; k < 8; k++)
      for (int m = 0; m < 2; m++) begin
        logic [31:0] d;
        logic [7:0] em;
        em = 8'(m) << k;
        d = {4'hF, em[7:6], 4'h0, em[5:0], 16'h0};
        wr(4'b1100, d);
        err_in = 8'h1 << k;
        #1;
        chk("R5 err enabled bit", irq_out, 32'(m));
        err_in = ~(8'h1 << k);
        #1;
        chk("R5 other errs", irq_out, 0);
        err_in = 0;
      end

    wr(4'b1100, 32'h0FFF0000);
    pulse(4'hF);
    chk("R4 all pending", irq_out, 1);
    wr(4'b1100, 32'hF0000000);
    chk("R8 mass clear", rd_data[31:16], 0);
    chk("R8 irq low", irq_out, 0);
    pulse(4'h3);
    chk("R8 lines disabled", irq_out, 0);
    chk("R8 model", rd_data, exp_rd());

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule